// File: doc/BRIEF.md
# Serial Flash Page-Program Engine

This block is the device-side command logic of a small serial NOR flash. A host drives chip select, serial clock and data in using SPI mode 0. The block returns data on a single output. The block oversamples the serial lines with its own system clock and assembles command bytes. It decodes four opcodes: write-enable, read-status, page-program and a plain data read. The data read exists so that programmed contents can be inspected through the serial port. The memory array is behavioural and sized for simulation. It resets to the erased value 0xFF.

A page-program command carries a 24-bit address, most significant bit first, followed by data bytes. The data bytes fill a page buffer. The buffer index wraps inside the page. The command takes effect only when chip select returns high cleanly on a byte boundary and every acceptance rule holds. Only the bytes actually sent are then merged into the array with a bitwise AND, so bits can only move from 1 to 0. A busy period of a fixed number of system clocks follows. During it only read-status is served. At its end, busy and the write-enable latch both clear. Three block-protect bits, driven in as a static configuration, fence off an upper part of the array.

Top module: `flashpp_top`

## Requirements
- R1: After reset the status byte reads 0x00 apart from the protect field, and every array byte reads 0xFF.
- R2: Opcode 0x06, received while not busy, sets the write-enable latch once its eighth bit is sampled.
- R3: Opcode 0x05 returns the status byte MSB first. Bit 0 is busy, bit 1 is the write-enable latch, bits 4:2 are the protect field, and bits 7:5 are 0. The byte repeats for as long as clocks continue. Data in is sampled on the rising clock edge. Data out changes after the falling edge.
- R4: Opcode 0x02, followed by a 24-bit address and data bytes, ANDs each sent byte into the addressed page. Bytes of the page that were not sent keep their old value. Opcode 0x03, followed by a 24-bit address, streams array bytes from that address upward.
- R5: A program command issued while the write-enable latch is 0 changes nothing.
- R6: A program command with an odd start address (address bit 0 = 1) changes nothing, and the latch stays 1.
- R7: A program command with fewer than two data bytes changes nothing.
- R8: A program command whose chip-select release falls anywhere other than directly after a byte's eighth bit changes nothing.
- R9: The buffer index advances through the low 8 address bits and wraps from 0xFF to 0x00. When more than 256 bytes are sent, the later bytes replace the earlier ones in the buffer.
- R10: After an accepted release, busy reads 1 for TPP_CYCLES system clocks. While busy, program and data-read commands are ignored (a data read returns 0x00), but read-status is served.
- R11: When the busy period ends, busy and the write-enable latch read 0. The latch stays 1 for the whole busy period.
- R12: With protect value k, k=0 protects nothing and k=7 protects every page. For k in 1..6, the top NUM_PAGES/2^(7-k) pages are protected. A program aimed at a protected page changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial lines |
| rst_n | input | 1 | Active-low synchronous reset |
| bp_cfg | input | 3 | Block-protect field value |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock, mode 0 |
| mosi | input | 1 | Serial data into the device |
| miso | output | 1 | Serial data out of the device |

## Verification
The bench builds the block with a 16 KiB array, which gives 64 pages. At that size, protect value 1 already guards exactly one page, so every step of the protection decode from 0 to 7 has a page on each side of its boundary. TPP_CYCLES is set to 1000. That is long enough for a status poll, a data read and a second program to all land inside one busy period, and short enough for dozens of accepted programs per run.

// File: rtl/flashpp_pkg.sv
package flashpp_pkg;
  localparam logic [7:0] OP_PROG = 8'h02;
  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WREN = 8'h06;

  // Status byte layout: busy bit0, latch bit1, protect field bits 4:2.
  function automatic logic [7:0] status_byte(logic busy, logic wel, logic [2:0] bp);
    return {3'b000, bp, wel, busy};
  endfunction

  // Upper-region guard: span of guarded pages doubles per protect step.
  function automatic logic page_locked(logic [2:0] bp, int unsigned page, int unsigned pages);
    int unsigned span;
    if (bp == 3'd0) return 1'b0;
    if (bp == 3'd7) return 1'b1;
    span = pages >> (3'd7 - bp);
    return (page >= pages - span);
  endfunction
endpackage

// File: rtl/flashpp_spi_rx.sv
module flashpp_spi_rx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sck,
  input  logic       mosi,
  output logic       sck_fall,
  output logic       byte_done,
  output logic [7:0] byte_val,
  output logic [2:0] byte_num,
  output logic       cs_rise,
  output logic       bit_zero
);
  logic       sck_q, cs_q, sck_rise;
  logic [2:0] bitcnt;
  logic [6:0] shreg;

  assign sck_rise  = ~cs_n & sck & ~sck_q;
  assign sck_fall  = ~cs_n & ~sck & sck_q;
  assign byte_done = sck_rise & (bitcnt == 3'd7);
  assign byte_val  = {shreg, mosi};
  assign cs_rise   = cs_n & ~cs_q;
  assign bit_zero  = (bitcnt == 3'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_q    <= 1'b0;
      cs_q     <= 1'b1;
      bitcnt   <= '0;
      shreg    <= '0;
      byte_num <= '0;
    end else begin
      sck_q <= sck;
      cs_q  <= cs_n;
      if (cs_n) begin
        bitcnt   <= '0;
        byte_num <= '0;
      end else if (sck_rise) begin
        bitcnt <= bitcnt + 3'd1;
        shreg  <= {shreg[5:0], mosi};
        if (bitcnt == 3'd7 && byte_num != 3'd7) byte_num <= byte_num + 3'd1;
      end
    end
  end
endmodule

// File: rtl/flashpp_array.sv
module flashpp_array #(
  parameter int MEM_BYTES  = 4096,
  parameter int PAGE_BYTES = 256
) (
  input  logic                                         clk,
  input  logic                                         rst_n,
  input  logic                                         buf_we,
  input  logic [$clog2(PAGE_BYTES)-1:0]                buf_idx,
  input  logic [7:0]                                   buf_val,
  input  logic                                         buf_clr,
  input  logic                                         commit,
  input  logic [$clog2(MEM_BYTES)-$clog2(PAGE_BYTES)-1:0] commit_page,
  input  logic [$clog2(MEM_BYTES)-1:0]                 rd_addr,
  output logic [7:0]                                   rd_val
);
  localparam int PW = $clog2(PAGE_BYTES);

  logic [7:0]            mem  [MEM_BYTES];
  logic [7:0]            pbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pmask;

  // One buffer lane per page byte.
  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (buf_we && buf_idx == PW'(g)) pbuf[g] <= buf_val;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pmask <= '0;
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'hFF;
    end else begin
      if (buf_clr) pmask <= '0;
      else if (buf_we) pmask[buf_idx] <= 1'b1;
      if (commit) begin
        for (int i = 0; i < PAGE_BYTES; i++) begin
          if (pmask[i]) mem[{commit_page, PW'(i)}] <= mem[{commit_page, PW'(i)}] & pbuf[i];
        end
      end
    end
  end

  assign rd_val = mem[rd_addr];
endmodule

// File: rtl/flashpp_ctrl.sv
module flashpp_ctrl
  import flashpp_pkg::*;
#(
  parameter int AW        = 12,
  parameter int PW        = 8,
  parameter int TPP       = 1000,
  parameter int NUM_PAGES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       bp_cfg,
  input  logic             sck_fall,
  input  logic             byte_done,
  input  logic [7:0]       byte_val,
  input  logic [2:0]       byte_num,
  input  logic             cs_rise,
  input  logic             bit_zero,
  input  logic [7:0]       rd_val,
  output logic             miso,
  output logic             buf_we,
  output logic [PW-1:0]    buf_idx,
  output logic             buf_clr,
  output logic             commit,
  output logic [AW-PW-1:0] commit_page,
  output logic [AW-1:0]    rd_addr,
  output logic             busy,
  output logic             wel,
  output logic             pp_start,
  output logic             pp_done,
  output logic             addr_odd,
  output logic             locked
);
  localparam int TW = $clog2(TPP + 1);

  logic [7:0]    opcode, cur_op, tx_sh;
  logic [23:0]   addr, full_addr;
  logic [PW-1:0] wptr;
  logic [1:0]    ndata;
  logic [TW-1:0] tcnt;
  logic [AW-1:0] rd_ptr;
  logic          miso_q;

  assign cur_op      = (byte_num == 3'd0) ? byte_val : opcode;
  assign full_addr   = {addr[15:0], byte_val};
  assign addr_odd    = addr[0];
  assign commit_page = addr[AW-1:PW];
  assign locked      = page_locked(bp_cfg, 32'(commit_page), NUM_PAGES);
  assign pp_start    = cs_rise & bit_zero & (opcode == OP_PROG) & ~busy & wel
                     & (ndata == 2'd2) & ~addr_odd & ~locked;
  assign pp_done     = busy & (tcnt == '0);
  assign buf_clr     = byte_done & (byte_num == 3'd0) & (byte_val == OP_PROG) & ~busy;
  assign buf_we      = byte_done & (byte_num >= 3'd4) & (opcode == OP_PROG) & ~busy;
  assign buf_idx     = wptr;
  assign commit      = pp_start;
  assign rd_addr     = (byte_num == 3'd3) ? full_addr[AW-1:0] : rd_ptr;
  assign miso        = miso_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      opcode <= '0; addr <= '0; wptr <= '0; ndata <= '0; tcnt <= '0;
      rd_ptr <= '0; tx_sh <= '0; miso_q <= 1'b0; busy <= 1'b0; wel <= 1'b0;
    end else begin
      if (cs_rise) begin
        opcode <= '0;
        ndata  <= '0;
      end else if (byte_done) begin
        if (byte_num == 3'd0) begin
          opcode <= (busy && byte_val != OP_RDSR) ? 8'h00 : byte_val;
          ndata  <= '0;
        end
        if (byte_num >= 3'd1 && byte_num <= 3'd3) addr <= full_addr;
        if (byte_num == 3'd3) begin
          wptr   <= full_addr[PW-1:0];
          rd_ptr <= full_addr[AW-1:0] + 1'b1;
        end
        if (buf_we) begin
          wptr <= wptr + 1'b1;
          if (ndata != 2'd2) ndata <= ndata + 2'd1;
        end
        if (byte_num >= 3'd4 && opcode == OP_READ) rd_ptr <= rd_ptr + 1'b1;
        if (cur_op == OP_RDSR)                          tx_sh <= status_byte(busy, wel, bp_cfg);
        else if (opcode == OP_READ && byte_num >= 3'd3) tx_sh <= rd_val;
        else                                            tx_sh <= 8'h00;
      end else if (sck_fall) begin
        miso_q <= tx_sh[7];
        tx_sh  <= {tx_sh[6:0], 1'b0};
      end
      if (pp_start) begin
        busy <= 1'b1;
        tcnt <= TW'(TPP - 1);
      end else if (busy) begin
        if (tcnt == '0) busy <= 1'b0;
        else            tcnt <= tcnt - 1'b1;
      end
      if (pp_done) wel <= 1'b0;
      else if (byte_done && byte_num == 3'd0 && byte_val == OP_WREN && !busy) wel <= 1'b1;
    end
  end
endmodule

// File: rtl/flashpp_top.sv
module flashpp_top
  import flashpp_pkg::*;
#(
  parameter int MEM_BYTES  = 4096,
  parameter int PAGE_BYTES = 256,
  parameter int TPP_CYCLES = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] bp_cfg,
  input  logic       cs_n,
  input  logic       sck,
  input  logic       mosi,
  output logic       miso
);
  localparam int AW        = $clog2(MEM_BYTES);
  localparam int PW        = $clog2(PAGE_BYTES);
  localparam int NUM_PAGES = MEM_BYTES / PAGE_BYTES;

  logic             sck_fall, byte_done, cs_rise, bit_zero;
  logic [7:0]       byte_val, rd_val;
  logic [2:0]       byte_num;
  logic             buf_we, buf_clr, commit;
  logic [PW-1:0]    buf_idx;
  logic [AW-PW-1:0] commit_page;
  logic [AW-1:0]    rd_addr;
  logic             busy, wel, pp_start, pp_done, addr_odd, locked;

  flashpp_spi_rx u_rx (
    .clk, .rst_n, .cs_n, .sck, .mosi,
    .sck_fall, .byte_done, .byte_val, .byte_num, .cs_rise, .bit_zero
  );

  flashpp_ctrl #(.AW(AW), .PW(PW), .TPP(TPP_CYCLES), .NUM_PAGES(NUM_PAGES)) u_ctrl (
    .clk, .rst_n, .bp_cfg, .sck_fall, .byte_done, .byte_val, .byte_num, .cs_rise,
    .bit_zero, .rd_val, .miso, .buf_we, .buf_idx, .buf_clr, .commit, .commit_page,
    .rd_addr, .busy, .wel, .pp_start, .pp_done, .addr_odd, .locked
  );

  flashpp_array #(.MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES)) u_arr (
    .clk, .rst_n, .buf_we, .buf_idx, .buf_val(byte_val), .buf_clr, .commit,
    .commit_page, .rd_addr, .rd_val
  );
endmodule

// File: rtl/flashpp_chk.sv
module flashpp_chk (
  input logic clk,
  input logic rst_n,
  input logic byte_done,
  input logic busy,
  input logic wel,
  input logic pp_start,
  input logic pp_done,
  input logic addr_odd,
  input logic locked
);
  AST_BUSY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    pp_start |=> busy); // R10
  AST_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(pp_done)); // R10
  AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    pp_done |=> !busy && !wel); // R11
  AST_WEL_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> wel); // R11
  AST_WEL_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> $past(byte_done) && !$past(busy)); // R2
  AST_START_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    pp_start |-> !addr_odd); // R6
  AST_START_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    pp_start |-> !locked); // R12
endmodule

bind flashpp_top flashpp_chk u_chk (
  .clk(clk), .rst_n(rst_n), .byte_done(byte_done), .busy(busy), .wel(wel),
  .pp_start(pp_start), .pp_done(pp_done), .addr_odd(addr_odd), .locked(locked)
);

// File: tb/flashpp_top_test.sv
`timescale 1ns/1ps
module flashpp_top_test;
  localparam int MEMB = 16384;
  localparam int NP   = MEMB / 256;
  localparam int TPP  = 1000;
  localparam int HALF = 2;

  logic       clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic [2:0] bp = 3'd0;
  logic       miso;
  int         n_tests = 0, n_fail = 0, cyc = 0;
  bit         finished = 0, tb_wel = 0;
  logic [7:0] mdl [MEMB];
  logic [7:0] pdata [300];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  flashpp_top #(.MEM_BYTES(MEMB), .PAGE_BYTES(256), .TPP_CYCLES(TPP)) uut (
    .clk(clk), .rst_n(rst_n), .bp_cfg(bp), .cs_n(cs_n), .sck(sck), .mosi(mosi), .miso(miso)
  );

  task automatic check(bit ok, string req, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(int n); repeat (n) @(negedge clk); endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int b = 7; b >= 0; b--) begin
      mosi = tx[b];
      tick(HALF);
      rx[b] = miso;
      sck = 1'b1;
      tick(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic cs_low;  cs_n = 1'b0; tick(2); endtask
  task automatic cs_high; tick(2); cs_n = 1'b1; tick(3); endtask

  task automatic rdsr(output logic [7:0] st);
    logic [7:0] j;
    cs_low; xfer(8'h05, j); xfer(8'h00, st); cs_high;
  endtask

  task automatic wren;
    logic [7:0] j;
    cs_low; xfer(8'h06, j); cs_high;
    tb_wel = 1;
  endtask

  function automatic bit tb_locked(logic [2:0] k, int page);
    if (k == 3'd0) return 0;
    if (k == 3'd7) return 1;
    return page * 64 >= NP * (64 - (1 << (k - 1)));
  endfunction

  task automatic read_chk(int start, int n, string req);
    logic [7:0] j, d;
    int bad = -1, act = 0, exp = 0;
    cs_low; xfer(8'h03, j);
    xfer(8'(start >> 16), j); xfer(8'(start >> 8), j); xfer(8'(start), j);
    for (int i = 0; i < n; i++) begin
      xfer(8'h00, d);
      if (bad < 0 && d !== mdl[(start + i) % MEMB]) begin
        bad = i; act = d; exp = mdl[(start + i) % MEMB];
      end
    end
    cs_high;
    check(bad < 0, req, act, exp);
  endtask

  task automatic wait_ready(output int waited);
    logic [7:0] st;
    int t0 = cyc;
    for (int p = 0; p < 200; p++) begin
      rdsr(st);
      if (st[0] == 1'b0) break;
    end
    waited = cyc - t0;
  endtask

  // Issues a program; updates the model when the rules say it is accepted.
  task automatic do_prog(int addr, int n, int extra, bit busy_now, output bit acc);
    logic [7:0] j;
    logic [7:0] stage [256];
    bit         sent [256];
    int         base, off;
    acc = tb_wel && !busy_now && (addr % 2 == 0) && n >= 2 && extra == 0
          && !tb_locked(bp, (addr % MEMB) / 256);
    cs_low; xfer(8'h02, j);
    xfer(8'(addr >> 16), j); xfer(8'(addr >> 8), j); xfer(8'(addr), j);
    for (int i = 0; i < n; i++) xfer(pdata[i], j);
    for (int i = 0; i < extra; i++) begin
      mosi = 1'b1; tick(HALF); sck = 1'b1; tick(HALF); sck = 1'b0;
    end
    cs_high;
    if (acc) begin
      for (int i = 0; i < 256; i++) sent[i] = 0;
      base = (addr % MEMB) & ~255;
      for (int i = 0; i < n; i++) begin
        off = ((addr & 255) + i) % 256;
        stage[off] = pdata[i];
        sent[off] = 1;
      end
      for (int i = 0; i < 256; i++) if (sent[i]) mdl[base + i] = mdl[base + i] & stage[i];
    end
  endtask

  task automatic fill(int n);
    for (int i = 0; i < n; i++) pdata[i] = 8'($urandom);
  endtask

  task automatic prog_done(int addr, int n, string req);
    bit acc;
    int w;
    logic [7:0] st;
    wren;
    do_prog(addr, n, 0, 0, acc);
    wait_ready(w);
    tb_wel = acc ? 0 : tb_wel;
    rdsr(st);
    check(st == {3'b000, bp, tb_wel, 1'b0}, req, st, {3'b000, bp, tb_wel, 1'b0});
    read_chk((addr + MEMB - 4) % MEMB, n + 8, req);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] st, j, d0, d1;
    bit acc;
    int w;
    void'($urandom(32'd20240611));
    for (int i = 0; i < MEMB; i++) mdl[i] = 8'hFF;
    tick(10); rst_n = 1'b1; tick(4);

    // R1: reset state
    rdsr(st); check(st == 8'h00, "R1 status after reset", st, 8'h00);
    read_chk(0, 16, "R1 erased array");
    read_chk(MEMB - 8, 8, "R1 erased array end");

    // R3: protect field shows in bits 4:2
    bp = 3'd5; rdsr(st); check(st == 8'h14, "R3 protect field", st, 8'h14);
    bp = 3'd0;

    // R5: no latch -> ignored
    fill(4); do_prog(24'h000100, 4, 0, 0, acc);
    rdsr(st); check(st == 8'h00, "R5 status", st, 8'h00);
    read_chk(24'h0000FC, 12, "R5 array unchanged");

    // R2 / R3: latch set, status repeats
    wren;
    cs_low; xfer(8'h05, j); xfer(8'h00, d0); xfer(8'h00, d1); cs_high;
    check(d0 == 8'h02, "R2 latch set", d0, 8'h02);
    check(d1 == 8'h02, "R3 status repeats", d1, 8'h02);

    // R4 / R10: accepted program, then commands during busy
    pdata[0] = 8'hA5; pdata[1] = 8'h3C; pdata[2] = 8'h0F; pdata[3] = 8'hF0;
    do_prog(24'h000200, 4, 0, 0, acc);
    rdsr(st); check(st == 8'h03, "R10 busy and latch during cycle", st, 8'h03);
    cs_low; xfer(8'h03, j); xfer(8'h00, j); xfer(8'h02, j); xfer(8'h00, j);
    xfer(8'h00, d0); cs_high;
    check(d0 == 8'h00, "R10 read ignored while busy", d0, 8'h00);
    fill(4); do_prog(24'h000300, 4, 0, 1, acc);
    wait_ready(w);
    check(w >= TPP - 500 && w <= TPP + 200, "R10 busy length", w, TPP);
    tb_wel = 0;
    rdsr(st); check(st == 8'h00, "R11 busy and latch clear", st, 8'h00);
    read_chk(24'h0001FC, 12, "R4 program and neighbours");
    read_chk(24'h0002FC, 12, "R10 program while busy ignored");

    // R4: AND-only behaviour on a second pass
    pdata[0] = 8'h5A; pdata[1] = 8'hFF;
    prog_done(24'h000200, 2, "R4 bits only clear");

    // R6: odd address
    wren; fill(4); do_prog(24'h000301, 4, 0, 0, acc);
    rdsr(st); check(st == 8'h02, "R6 latch kept", st, 8'h02);
    read_chk(24'h0002FC, 12, "R6 array unchanged");

    // R7: one data byte
    fill(1); do_prog(24'h000400, 1, 0, 0, acc);
    rdsr(st); check(st == 8'h02, "R7 no cycle started", st, 8'h02);
    read_chk(24'h0003FE, 4, "R7 array unchanged");

    // R8: release off the byte boundary
    fill(4); do_prog(24'h000500, 4, 3, 0, acc);
    rdsr(st); check(st == 8'h02, "R8 no cycle started", st, 8'h02);
    read_chk(24'h0004FE, 8, "R8 array unchanged");

    // R9: wrap inside page, overwrite past 256 bytes
    fill(40); prog_done(24'h0006F0, 40, "R9 wrap");
    read_chk(24'h000600, 256, "R9 wrap page view");
    fill(260); prog_done(24'h000700, 260, "R9 overwrite");
    read_chk(24'h000700, 256, "R9 overwrite page view");

    // R12: protection decode boundaries
    bp = 3'd1; fill(2);
    prog_done(24'h003F00, 2, "R12 k1 top page guarded");
    fill(2); prog_done(24'h003E00, 2, "R12 k1 next page open");
    bp = 3'd6; fill(2);
    prog_done(24'h002000, 2, "R12 k6 half guarded");
    fill(2); prog_done(24'h001F00, 2, "R12 k6 lower half open");
    bp = 3'd7; fill(2);
    prog_done(24'h000000, 2, "R12 k7 all guarded");
    bp = 3'd0;

    // R4: random programs
    for (int r = 0; r < 10; r++) begin
      int a, n;
      a = int'($urandom_range(0, MEMB - 1)) & ~1;
      n = int'($urandom_range(2, 24));
      fill(n);
      prog_done(a, n, "R4 random program");
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule